// File: doc/BRIEF.md
# Hall Six-Step Commutation Controller

This block converts three digitized Hall sensor bits into six-step drive enables for a three-phase brushless motor. In every valid step exactly one upper switch and one lower switch of different legs are enabled. A direction input selects forward or reverse rotation, a start/stop input turns the drive on or off, and a brake input applies a short brake. It does this by enabling all lower switches.

The upper switches alone are chopped by an externally generated PWM on-signal. An overcurrent flag cuts the upper switches for the rest of the current PWM period. The lower switch of the active step stays on for the whole step. All six enables come from one register stage, so every input reaches the outputs on the first clock edge after it is applied.

Top module: `hall_commutator`

## Requirements
- R1: In forward run, with hall_in = {IN1,IN2,IN3} (IN1 at bit 2) and enable bit 0 = U, bit 1 = V, bit 2 = W, the codes map as upper/lower: 101 to V/U, 100 to W/U, 110 to W/V, 010 to U/V, 011 to U/W, 001 to V/W.
- R2: In reverse run, the block uses the R1 table indexed by the bitwise inverse of hall_in.
- R3: Hall codes 000 and 111 turn all six enables off while running.
- R4: stop_in = 1 turns all six enables off on the next clock edge, whatever the other inputs are.
- R5: brake_in = 1 while running gives lo_en = 111 and hi_en = 000, regardless of the Hall code and PWM.
- R6: Once applied, the brake stays in force while running even after brake_in falls. It is released only by a clock edge with stop_in = 1 and brake_in = 0.
- R7: dir_rev_in (0 = forward, 1 = reverse) is captured only on edges with stop_in = 1. A change while running has no effect on the outputs.
- R8: pwm_on_in = 0 clears hi_en while lo_en keeps the step's lower switch on.
- R9: oc_in = 1 clears hi_en on the next edge. hi_en stays cleared until pwm_on_in next rises with oc_in low, and lo_en is unaffected.
- R10: During and right after synchronous reset (rst = 1), all enables are off, the direction is forward and no brake is held.
- R11: At no time is more than one upper enable set, or an upper and lower enable of the same leg set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Hall bits, IN1 at bit 2, IN3 at bit 0 |
| dir_rev_in | input | 1 | 0 forward, 1 reverse |
| stop_in | input | 1 | 1 stop, 0 run |
| brake_in | input | 1 | 1 requests short brake |
| pwm_on_in | input | 1 | PWM on-phase for upper switches |
| oc_in | input | 1 | Overcurrent flag |
| hi_en | output | 3 | Upper switch enables, bit 0 U, bit 1 V, bit 2 W |
| lo_en | output | 3 | Lower switch enables, bit 0 U, bit 1 V, bit 2 W |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it: Hall decoding, stop, brake, PWM chop and overcurrent blanking. The same holds for the latched brake and the captured direction, which act from the edge after they are loaded. The driver applies each input vector at a falling edge and queues the expected enables for it. The monitor pops one item a quarter period after the next rising edge, so each comparison falls on that single register stage. Direction and brake release are staged over several cycles to confirm that they act only through the stop state.

// File: rtl/hall_step_pkg.sv
package hall_step_pkg;

    localparam int NPHASE = 3;
    localparam int HALL_W = 3;

    typedef logic [NPHASE-1:0] leg_t;
    typedef logic [HALL_W-1:0] hall_t;

    typedef struct packed {
        leg_t hi;
        leg_t lo;
    } drive_t;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_BRAKE = 2'd1,
        MODE_RUN   = 2'd2
    } mode_e;

    localparam leg_t LEG_U    = leg_t'(1);
    localparam leg_t LEG_V    = leg_t'(2);
    localparam leg_t LEG_W    = leg_t'(4);
    localparam leg_t LEG_NONE = '0;
    localparam leg_t LEG_ALL  = '1;

    // Forward step table; code bit 2 is the first Hall sensor.
    function automatic drive_t forward_step(input hall_t code);
        drive_t d;
        case (code)
            3'b101:  d = '{hi: LEG_V, lo: LEG_U};
            3'b100:  d = '{hi: LEG_W, lo: LEG_U};
            3'b110:  d = '{hi: LEG_W, lo: LEG_V};
            3'b010:  d = '{hi: LEG_U, lo: LEG_V};
            3'b011:  d = '{hi: LEG_U, lo: LEG_W};
            3'b001:  d = '{hi: LEG_V, lo: LEG_W};
            default: d = '{hi: LEG_NONE, lo: LEG_NONE};
        endcase
        return d;
    endfunction

    function automatic logic code_valid(input hall_t code);
        return (code != '0) && (code != '1);
    endfunction

endpackage

// File: rtl/step_decode.sv
module step_decode
    import hall_step_pkg::*;
(
    input  hall_t  hall,
    input  logic   rev,
    output drive_t drv,
    output logic   valid
);
    hall_t idx;

    always_comb begin
        idx   = rev ? ~hall : hall;
        drv   = forward_step(idx);
        valid = code_valid(hall);
    end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import hall_step_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stop_req,
    input  logic  brake_req,
    input  logic  rev_req,
    output mode_e mode,
    output logic  dir_rev
);
    logic brk_hold_q;
    logic dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_hold_q <= 1'b0;
            dir_q      <= 1'b0;
        end else begin
            if (brake_req)
                brk_hold_q <= 1'b1;
            else if (stop_req)
                brk_hold_q <= 1'b0;
            if (stop_req)
                dir_q <= rev_req;
        end
    end

    always_comb begin
        if (stop_req)
            mode = MODE_OFF;
        else if (brake_req || brk_hold_q)
            mode = MODE_BRAKE;
        else
            mode = MODE_RUN;
    end

    assign dir_rev = dir_q;

    AST_DIR_FROZEN_RUN: assert property (@(posedge clk) disable iff (rst)
        !stop_req |=> $stable(dir_q)); // R7

    AST_BRAKE_HELD: assert property (@(posedge clk) disable iff (rst)
        (brk_hold_q && !stop_req) |=> brk_hold_q); // R6
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate (
    input  logic clk,
    input  logic rst,
    input  logic pwm_on,
    input  logic oc_flag,
    output logic hi_allow
);
    logic pwm_prev_q;
    logic blank_q;
    logic pwm_rise;

    assign pwm_rise = pwm_on && !pwm_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_prev_q <= 1'b0;
            blank_q    <= 1'b0;
        end else begin
            pwm_prev_q <= pwm_on;
            if (oc_flag)
                blank_q <= 1'b1;
            else if (pwm_rise)
                blank_q <= 1'b0;
        end
    end

    assign hi_allow = pwm_on && !oc_flag && !(blank_q && !pwm_rise);

    AST_OC_SETS_BLANK: assert property (@(posedge clk) disable iff (rst)
        oc_flag |=> blank_q); // R9
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_rev_in,
    input  logic       stop_in,
    input  logic       brake_in,
    input  logic       pwm_on_in,
    input  logic       oc_in,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en
);
    mode_e  mode;
    logic   dir_rev;
    drive_t drv;
    logic   drv_valid;
    logic   hi_allow;
    drive_t out_q;

    mode_ctrl u_mode (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (stop_in),
        .brake_req (brake_in),
        .rev_req   (dir_rev_in),
        .mode      (mode),
        .dir_rev   (dir_rev)
    );

    step_decode u_dec (
        .hall  (hall_in),
        .rev   (dir_rev),
        .drv   (drv),
        .valid (drv_valid)
    );

    pwm_gate u_pwm (
        .clk      (clk),
        .rst      (rst),
        .pwm_on   (pwm_on_in),
        .oc_flag  (oc_in),
        .hi_allow (hi_allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{hi: LEG_NONE, lo: LEG_NONE};
        end else begin
            unique case (mode)
                MODE_BRAKE: out_q <= '{hi: LEG_NONE, lo: LEG_ALL};
                MODE_RUN: begin
                    if (drv_valid)
                        out_q <= '{hi: drv.hi & {NPHASE{hi_allow}}, lo: drv.lo};
                    else
                        out_q <= '{hi: LEG_NONE, lo: LEG_NONE};
                end
                default: out_q <= '{hi: LEG_NONE, lo: LEG_NONE};
            endcase
        end
    end

    assign hi_en = out_q.hi;
    assign lo_en = out_q.lo;

    AST_HI_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hi_en)); // R11
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        (hi_en & lo_en) == 3'b000); // R11
    AST_STOP_OFF: assert property (@(posedge clk) disable iff (rst)
        stop_in |=> (hi_en == 3'b000 && lo_en == 3'b000)); // R4
    AST_BRAKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (brake_in && !stop_in) |=> (lo_en == 3'b111 && hi_en == 3'b000)); // R5
    AST_PWM_OFF_HI: assert property (@(posedge clk) disable iff (rst)
        !pwm_on_in |=> hi_en == 3'b000); // R8
    AST_OC_CUT: assert property (@(posedge clk) disable iff (rst)
        oc_in |=> hi_en == 3'b000); // R9
    AST_RESET_OFF: assert property (@(posedge clk)
        rst |=> (hi_en == 3'b000 && lo_en == 3'b000)); // R10
endmodule

// File: tb/hall_commutator_test.sv
module hall_commutator_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hall_in;
    logic       dir_rev_in, stop_in, brake_in, pwm_on_in, oc_in;
    logic [2:0] hi_en, lo_en;

    typedef struct {
        logic       check;
        logic [2:0] hi;
        logic [2:0] lo;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hall_commutator uut (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_rev_in(dir_rev_in),
        .stop_in(stop_in), .brake_in(brake_in), .pwm_on_in(pwm_on_in),
        .oc_in(oc_in), .hi_en(hi_en), .lo_en(lo_en)
    );

    // Expected pair from the requirement table (R1, R2): {hi, lo}
    function automatic logic [5:0] ref_pair(input logic [2:0] code, input logic rev);
        logic [2:0] c;
        c = rev ? ~code : code;
        case (c)
            3'b101:  return {3'b010, 3'b001};
            3'b100:  return {3'b100, 3'b001};
            3'b110:  return {3'b100, 3'b010};
            3'b010:  return {3'b001, 3'b010};
            3'b011:  return {3'b001, 3'b100};
            3'b001:  return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic drive(input logic r, input logic [2:0] h, input logic dr,
                         input logic st, input logic bk, input logic pw,
                         input logic oc, input logic chk,
                         input logic [2:0] ehi, input logic [2:0] elo,
                         input string req);
        exp_t e;
        @(negedge clk);
        rst = r; hall_in = h; dir_rev_in = dr; stop_in = st;
        brake_in = bk; pwm_on_in = pw; oc_in = oc;
        e.check = chk; e.hi = ehi; e.lo = elo; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic run_step(input logic [2:0] h, input logic dr, input string req);
        logic [5:0] p;
        p = ref_pair(h, dr);
        drive(0, h, dr, 0, 0, 1, 0, 1, p[5:3], p[2:0], req);
    endtask

    // Monitor: one item per rising edge, sampled a quarter period later.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.check) begin
                    total++;
                    if (hi_en !== e.hi || lo_en !== e.lo) begin
                        bad++;
                        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                                 e.req, hi_en, lo_en, e.hi, e.lo);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: hi=%b lo=%b expected run to end", hi_en, lo_en);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; hall_in = 3'b101; dir_rev_in = 0; stop_in = 1;
        brake_in = 0; pwm_on_in = 1; oc_in = 0;
        // R10: reset state
        drive(1, 3'b101, 0, 0, 0, 1, 0, 1, 3'b000, 3'b000, "R10");
        drive(1, 3'b101, 0, 0, 1, 1, 0, 1, 3'b000, 3'b000, "R10");
        // R10: forward, no brake held right after reset
        run_step(3'b101, 0, "R10");
        // R4: stop turns everything off
        drive(0, 3'b101, 0, 1, 0, 1, 0, 1, 3'b000, 3'b000, "R4");
        // R1: forward table
        run_step(3'b101, 0, "R1");
        run_step(3'b100, 0, "R1");
        run_step(3'b110, 0, "R1");
        run_step(3'b010, 0, "R1");
        run_step(3'b011, 0, "R1");
        run_step(3'b001, 0, "R1");
        // R3: invalid codes
        drive(0, 3'b000, 0, 0, 0, 1, 0, 1, 3'b000, 3'b000, "R3");
        drive(0, 3'b111, 0, 0, 0, 1, 0, 1, 3'b000, 3'b000, "R3");
        // R8: PWM off chops upper only
        drive(0, 3'b101, 0, 0, 0, 0, 0, 1, 3'b000, 3'b001, "R8");
        run_step(3'b101, 0, "R8");
        // R9: overcurrent blanks upper until next PWM rise
        drive(0, 3'b101, 0, 0, 0, 1, 1, 1, 3'b000, 3'b001, "R9");
        drive(0, 3'b101, 0, 0, 0, 1, 0, 1, 3'b000, 3'b001, "R9");
        drive(0, 3'b110, 0, 0, 0, 1, 0, 1, 3'b000, 3'b010, "R9");
        drive(0, 3'b110, 0, 0, 0, 0, 0, 1, 3'b000, 3'b010, "R9");
        drive(0, 3'b110, 0, 0, 0, 1, 0, 1, 3'b100, 3'b010, "R9");
        // R7: direction change while running ignored
        drive(0, 3'b101, 1, 0, 0, 1, 0, 1, 3'b010, 3'b001, "R7");
        drive(0, 3'b100, 1, 0, 0, 1, 0, 1, 3'b100, 3'b001, "R7");
        // Stop with reverse requested, then run reverse (R2)
        drive(0, 3'b101, 1, 1, 0, 1, 0, 1, 3'b000, 3'b000, "R4");
        run_step(3'b101, 1, "R2");
        run_step(3'b100, 1, "R2");
        run_step(3'b011, 1, "R2");
        // R7: switching back to forward while running ignored
        drive(0, 3'b101, 0, 0, 0, 1, 0, 1, 3'b001, 3'b010, "R7");
        // R5: brake while running
        drive(0, 3'b101, 0, 0, 1, 1, 0, 1, 3'b000, 3'b111, "R5");
        drive(0, 3'b011, 0, 0, 1, 0, 1, 1, 3'b000, 3'b111, "R5");
        // R6: brake held after pin release while running
        drive(0, 3'b101, 0, 0, 0, 1, 0, 1, 3'b000, 3'b111, "R6");
        drive(0, 3'b110, 0, 0, 0, 1, 0, 1, 3'b000, 3'b111, "R6");
        // R6: release through stop, direction now forward
        drive(0, 3'b101, 0, 1, 0, 1, 0, 1, 3'b000, 3'b000, "R4");
        run_step(3'b101, 0, "R6");
        // R4: stop dominates brake
        drive(0, 3'b101, 0, 1, 1, 1, 0, 1, 3'b000, 3'b000, "R4");
        drive(0, 3'b101, 0, 1, 0, 1, 0, 1, 3'b000, 3'b000, "R4");
        run_step(3'b001, 0, "R6");
        drive(0, 3'b001, 0, 0, 0, 1, 0, 0, 3'b000, 3'b000, "flush");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule